// File: doc/BRIEF.md
# Bidirectional YUV Video Expansion Port

This block is the half-duplex side port of a video processing device. In output direction it hands the internal decoder's byte-serial 4:2:2 stream to an external digital video circuit. The clock, data, valid flag and horizontal and vertical references go out as combinational copies of the decoder's own signals. In input direction it receives a 4:2:2 stream from that external circuit. The stream is either 8-bit byte-serial on the primary bus, or 16-bit with luminance on the primary bus and chrominance on a second bus. The block rebuilds chroma/luma pairs and places them in a small internal buffer, which the downstream logic drains through a show-ahead read interface.

Input line and field timing comes from one of two sources. The first is codes embedded in the stream that mark the start and end of active video. The second is a pair of external horizontal and vertical reference pins, each with a selectable active edge. A data-valid qualifier gates every byte, so a gated input clock is handled by holding the qualifier low. A ready flag tells the external sender when the buffer is close to full. The direction of the port only changes at a field boundary.

The direction controller has four states. DIR_OUT moves to DIR_OUT_WAIT when input is requested. DIR_OUT_WAIT goes back to DIR_OUT if the request is withdrawn, and goes on to DIR_IN on a rising decoder vertical reference. DIR_IN moves to DIR_IN_WAIT when the request drops. DIR_IN_WAIT goes back to DIR_IN if the request returns, and goes on to DIR_OUT on an input field event. The embedded-code detector has four states. CD_HUNT moves to CD_FF on an FF byte. CD_FF moves to CD_Z1 on 00. CD_Z1 moves to CD_Z2 on 00. CD_Z2 takes the status byte and returns to CD_HUNT. Any unexpected byte sends CD_FF or CD_Z1 back to CD_HUNT, or to CD_FF if that byte is FF.

Top module: `vid_xport`

## Requirements
- R1: After reset the port is in output direction, xp_oe is 1 while xp_tri is 0, the buffer is empty (rd_valid 0) and xp_rdy is 1.
- R2: While in output direction, xp_data_o, xp_valid_o, xp_h_o, xp_v_o and xp_clk_o equal dec_data, dec_valid, dec_href, dec_vref and clk in the same cycle, and xp_oe is 1.
- R3: xp_tri at 1 forces xp_oe to 0 in either direction.
- R4: A request for input (cfg_req_in 1) takes effect only at a rising edge of dec_vref. xp_oe falls one clock after the clock edge that samples that rising edge. A request withdrawn before such an edge leaves the port in output direction.
- R5: Dropping the request while in input direction returns the port to output only at an input field event: an active external vertical edge in external timing, or an embedded code whose field bit differs from the last one in embedded timing. xp_oe rises one clock later.
- R6: In 8-bit external timing, only bytes with xp_valid_i at 1 are taken, in the order Cb, Y, Cr, Y. They become buffer entries {c=Cb, y=Y} and {c=Cr, y=Y}. No byte is taken in output direction.
- R7: With cfg_wide at 1, every qualified byte makes one entry {c=xp_aux_i, y=xp_data_i}.
- R8: In external timing, the active edge of xp_h_i (rising when cfg_h_fall is 0, falling when it is 1) restarts the Cb/Y/Cr/Y phase, and a half-received pair is dropped.
- R9: In external timing, on the active edge of xp_v_i (rising when cfg_v_fall is 0, falling when it is 1), in_field_id takes the level of xp_h_i XOR cfg_fid_inv.
- R10: In embedded timing (cfg_embedded 1), a code is FF 00 00 followed by a status byte with bit 7 set. Bit 6 of the status byte is the field bit and bit 4 is 0 for start and 1 for end of active video. Only bytes between a start code and the next FF are stored. Code bytes are never stored. A code restarts the phase, and in_field_id takes the field bit XOR cfg_fid_inv.
- R11: xp_rdy is 1 exactly while at least 4 of the 8 buffer entries are free. A pair that arrives when the buffer is full is dropped.
- R12: The buffer returns entries in arrival order. rd_y and rd_c show the oldest entry while rd_valid is 1, and rd_en at 1 removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port and decoder clock |
| rst_n | input | 1 | Active-low reset |
| cfg_req_in | input | 1 | Requested direction, 1 = input |
| cfg_wide | input | 1 | 16-bit input using the second bus |
| cfg_embedded | input | 1 | Input timing from embedded codes |
| cfg_h_fall | input | 1 | Falling edge of xp_h_i is active |
| cfg_v_fall | input | 1 | Falling edge of xp_v_i is active |
| cfg_fid_inv | input | 1 | Invert the derived field ID |
| xp_tri | input | 1 | Force port drivers to high impedance |
| dec_data | input | 8 | Decoder byte stream |
| dec_valid | input | 1 | Decoder data-valid gate |
| dec_href | input | 1 | Decoder horizontal reference |
| dec_vref | input | 1 | Decoder vertical reference |
| xp_data_i | input | 8 | Port primary bus, input value |
| xp_aux_i | input | 8 | Second bus (chrominance in 16-bit input) |
| xp_valid_i | input | 1 | Input data-valid qualifier |
| xp_h_i | input | 1 | Horizontal reference input |
| xp_v_i | input | 1 | Vertical reference input |
| xp_clk_o | output | 1 | Clock driven onto the port |
| xp_data_o | output | 8 | Primary bus output value |
| xp_valid_o | output | 1 | Valid flag output value |
| xp_h_o | output | 1 | Horizontal reference output value |
| xp_v_o | output | 1 | Vertical reference output value |
| xp_oe | output | 1 | Output enable for all port drivers |
| xp_rdy | output | 1 | Ready to receive |
| in_field_id | output | 1 | Field ID derived from the input stream |
| rd_en | input | 1 | Remove the oldest buffer entry |
| rd_valid | output | 1 | Buffer holds an entry |
| rd_y | output | 8 | Luminance of the oldest entry |
| rd_c | output | 8 | Chrominance of the oldest entry |

## Verification
Pair assembly is tried with an 8-bit stream that has unqualified cycles carrying junk, and with a 16-bit stream. The first shows that the qualifier gates bytes and that Cb/Cr are placed correctly; the second shows that the second bus supplies chroma. A half-sent group cut by a horizontal edge, once with each edge sense, shows whether the phase restart uses the selected edge. An embedded-coded line with bytes before the start code and after the end code shows that code bytes and blanking bytes never reach the buffer. A burst of nine pairs without reads shows the ready threshold, the drop on a full buffer and the read order. Direction requests that are raised and withdrawn between boundaries separate boundary-aligned switching from switching on the request alone.

// File: rtl/vxp_pkg.sv
package vxp_pkg;

    typedef enum logic [1:0] {
        DIR_OUT      = 2'd0,
        DIR_OUT_WAIT = 2'd1,
        DIR_IN       = 2'd2,
        DIR_IN_WAIT  = 2'd3
    } dir_state_t;

    typedef enum logic [1:0] {
        CD_HUNT = 2'd0,
        CD_FF   = 2'd1,
        CD_Z1   = 2'd2,
        CD_Z2   = 2'd3
    } code_state_t;

    localparam int STATUS_VALID_BIT = 7;
    localparam int STATUS_FIELD_BIT = 6;
    localparam int STATUS_END_BIT   = 4;

endpackage

// File: rtl/vxp_dir_ctrl.sv
module vxp_dir_ctrl
    import vxp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic out_bound,
    input  logic in_bound,
    output logic dir_in
);

    dir_state_t state_q;
    dir_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIR_OUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIR_OUT:      if (req_in) state_d = DIR_OUT_WAIT;
            DIR_OUT_WAIT: begin
                if (!req_in)        state_d = DIR_OUT;
                else if (out_bound) state_d = DIR_IN;
            end
            DIR_IN:       if (!req_in) state_d = DIR_IN_WAIT;
            DIR_IN_WAIT: begin
                if (req_in)        state_d = DIR_IN;
                else if (in_bound) state_d = DIR_OUT;
            end
            default:      state_d = DIR_OUT;
        endcase
    end

    assign dir_in = (state_q == DIR_IN) || (state_q == DIR_IN_WAIT);

    // R4: entry into input direction only at an output field boundary
    assert_dir_in_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir_in) |-> $past(out_bound));

    // R5: return to output only at an input field event
    assert_dir_out_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dir_in) |-> $past(in_bound));

endmodule

// File: rtl/vxp_edge.sv
module vxp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic fall_sel,
    output logic evt
);

    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign evt = fall_sel ? (sig_q & ~sig) : (~sig_q & sig);

endmodule

// File: rtl/vxp_code_det.sv
module vxp_code_det
    import vxp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_en,
    input  logic [BYTE_W-1:0] byte_val,
    output logic              code_evt,
    output logic              code_field,
    output logic              code_end
);

    localparam logic [BYTE_W-1:0] ALL_ONES  = {BYTE_W{1'b1}};
    localparam logic [BYTE_W-1:0] ALL_ZEROS = {BYTE_W{1'b0}};

    code_state_t state_q;
    code_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CD_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        code_evt   = 1'b0;
        code_field = byte_val[STATUS_FIELD_BIT];
        code_end   = byte_val[STATUS_END_BIT];
        if (byte_en) begin
            unique case (state_q)
                CD_HUNT: if (byte_val == ALL_ONES) state_d = CD_FF;
                CD_FF: begin
                    if (byte_val == ALL_ZEROS)     state_d = CD_Z1;
                    else if (byte_val != ALL_ONES) state_d = CD_HUNT;
                end
                CD_Z1: begin
                    if (byte_val == ALL_ZEROS)     state_d = CD_Z2;
                    else if (byte_val == ALL_ONES) state_d = CD_FF;
                    else                           state_d = CD_HUNT;
                end
                CD_Z2: begin
                    code_evt = byte_val[STATUS_VALID_BIT];
                    state_d  = (byte_val == ALL_ONES) ? CD_FF : CD_HUNT;
                end
                default: state_d = CD_HUNT;
            endcase
        end
    end

    // R10: a code is reported only after the two zero bytes of the preamble
    assert_code_after_preamble_R10: assert property (@(posedge clk) disable iff (!rst_n)
        code_evt |-> (state_q == CD_Z2) && byte_en);

endmodule

// File: rtl/vxp_assembler.sv
module vxp_assembler #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              accept,
    input  logic              wide,
    input  logic [BYTE_W-1:0] byte_y,
    input  logic [BYTE_W-1:0] byte_c,
    output logic              push_en,
    output logic [BYTE_W-1:0] push_y,
    output logic [BYTE_W-1:0] push_c
);

    logic [1:0]        phase_q;
    logic [BYTE_W-1:0] c_hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= 2'd0;
            c_hold_q <= '0;
        end else if (restart) begin
            phase_q <= 2'd0;
        end else if (accept && !wide) begin
            phase_q <= phase_q + 2'd1;
            if (!phase_q[0]) c_hold_q <= byte_y;
        end
    end

    always_comb begin
        push_y = byte_y;
        if (wide) begin
            push_en = accept && !restart;
            push_c  = byte_c;
        end else begin
            push_en = accept && !restart && phase_q[0];
            push_c  = c_hold_q;
        end
    end

    // R8: a restart leaves the assembler at the chroma position
    assert_phase_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == 2'd0));

endmodule

// File: rtl/vxp_fifo.sv
module vxp_fifo #(
    parameter int BYTE_W   = 8,
    parameter int DEPTH    = 8,
    parameter int RDY_FREE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [BYTE_W-1:0] push_y,
    input  logic [BYTE_W-1:0] push_c,
    input  logic              pop_en,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_y,
    output logic [BYTE_W-1:0] rd_c,
    output logic              ready
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(DEPTH - RDY_FREE);
    localparam logic [PTR_W-1:0] LAST_C  = PTR_W'(DEPTH - 1);

    logic [BYTE_W-1:0] mem_y [DEPTH];
    logic [BYTE_W-1:0] mem_c [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              do_push;
    logic              do_pop;

    assign do_push  = push_en && (count_q != DEPTH_C);
    assign do_pop   = pop_en && (count_q != '0);
    assign rd_valid = (count_q != '0);
    assign rd_y     = mem_y[rd_ptr_q];
    assign rd_c     = mem_c[rd_ptr_q];
    assign ready    = (count_q <= LIMIT_C);

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_y[wr_ptr_q] <= push_y;
            mem_c[wr_ptr_q] <= push_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_C) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_C) ? '0 : rd_ptr_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R11: a full buffer never shows ready, and the fill never exceeds its depth
    assert_no_ready_when_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == DEPTH_C) |-> !ready);
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= DEPTH_C);

endmodule

// File: rtl/vid_xport.sv
module vid_xport #(
    parameter int BYTE_W   = 8,
    parameter int DEPTH    = 8,
    parameter int RDY_FREE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req_in,
    input  logic              cfg_wide,
    input  logic              cfg_embedded,
    input  logic              cfg_h_fall,
    input  logic              cfg_v_fall,
    input  logic              cfg_fid_inv,
    input  logic              xp_tri,
    input  logic [BYTE_W-1:0] dec_data,
    input  logic              dec_valid,
    input  logic              dec_href,
    input  logic              dec_vref,
    input  logic [BYTE_W-1:0] xp_data_i,
    input  logic [BYTE_W-1:0] xp_aux_i,
    input  logic              xp_valid_i,
    input  logic              xp_h_i,
    input  logic              xp_v_i,
    output logic              xp_clk_o,
    output logic [BYTE_W-1:0] xp_data_o,
    output logic              xp_valid_o,
    output logic              xp_h_o,
    output logic              xp_v_o,
    output logic              xp_oe,
    output logic              xp_rdy,
    output logic              in_field_id,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_y,
    output logic [BYTE_W-1:0] rd_c
);

    localparam logic [BYTE_W-1:0] ALL_ONES = {BYTE_W{1'b1}};

    logic dir_in;
    logic out_bound;
    logic in_bound;
    logic vref_q;
    logic h_evt;
    logic v_evt;
    logic byte_en;
    logic code_evt;
    logic code_field;
    logic code_end;
    logic active_q;
    logic field_last_q;
    logic accept;
    logic restart;
    logic push_en;
    logic [BYTE_W-1:0] push_y;
    logic [BYTE_W-1:0] push_c;

    // Output side: direct copies of the decoder signals
    assign xp_clk_o   = clk;
    assign xp_data_o  = dec_data;
    assign xp_valid_o = dec_valid;
    assign xp_h_o     = dec_href;
    assign xp_v_o     = dec_vref;
    assign xp_oe      = !dir_in && !xp_tri;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vref_q <= 1'b0;
        else        vref_q <= dec_vref;
    end
    assign out_bound = dec_vref && !vref_q;

    // Input timing sources
    vxp_edge u_h_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig      (xp_h_i),
        .fall_sel (cfg_h_fall),
        .evt      (h_evt)
    );

    vxp_edge u_v_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig      (xp_v_i),
        .fall_sel (cfg_v_fall),
        .evt      (v_evt)
    );

    assign byte_en = dir_in && xp_valid_i;

    vxp_code_det #(.BYTE_W(BYTE_W)) u_code_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_en    (byte_en),
        .byte_val   (xp_data_i),
        .code_evt   (code_evt),
        .code_field (code_field),
        .code_end   (code_end)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q     <= 1'b0;
            field_last_q <= 1'b0;
            in_field_id  <= 1'b0;
        end else if (cfg_embedded) begin
            if (code_evt) begin
                active_q     <= !code_end;
                field_last_q <= code_field;
                in_field_id  <= code_field ^ cfg_fid_inv;
            end else if (byte_en && (xp_data_i == ALL_ONES)) begin
                active_q <= 1'b0;
            end
        end else if (v_evt) begin
            in_field_id <= xp_h_i ^ cfg_fid_inv;
        end
    end

    assign in_bound = cfg_embedded ? (code_evt && (code_field != field_last_q)) : v_evt;
    assign restart  = cfg_embedded ? code_evt : h_evt;
    assign accept   = byte_en && (!cfg_embedded || (active_q && (xp_data_i != ALL_ONES)));

    vxp_dir_ctrl u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (cfg_req_in),
        .out_bound (out_bound),
        .in_bound  (in_bound),
        .dir_in    (dir_in)
    );

    vxp_assembler #(.BYTE_W(BYTE_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .accept  (accept),
        .wide    (cfg_wide),
        .byte_y  (xp_data_i),
        .byte_c  (xp_aux_i),
        .push_en (push_en),
        .push_y  (push_y),
        .push_c  (push_c)
    );

    vxp_fifo #(.BYTE_W(BYTE_W), .DEPTH(DEPTH), .RDY_FREE(RDY_FREE)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .push_y   (push_y),
        .push_c   (push_c),
        .pop_en   (rd_en),
        .rd_valid (rd_valid),
        .rd_y     (rd_y),
        .rd_c     (rd_c),
        .ready    (xp_rdy)
    );

    // R3/R5/R4: the port never drives while it receives
    assert_no_drive_in_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dir_in |-> !xp_oe);

    // R6: nothing enters the buffer while the port drives
    assert_no_push_in_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_in |-> !push_en);

endmodule

// File: tb/tb_vid_xport.sv
module tb_vid_xport;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_req_in = 0, cfg_wide = 0, cfg_embedded = 0;
    logic       cfg_h_fall = 0, cfg_v_fall = 0, cfg_fid_inv = 0, xp_tri = 0;
    logic [7:0] dec_data = 0;
    logic       dec_valid = 0, dec_href = 0, dec_vref = 0;
    logic [7:0] xp_data_i = 0, xp_aux_i = 0;
    logic       xp_valid_i = 0, xp_h_i = 0, xp_v_i = 0;
    logic       rd_en = 0;
    logic       xp_clk_o, xp_valid_o, xp_h_o, xp_v_o, xp_oe, xp_rdy, in_field_id, rd_valid;
    logic [7:0] xp_data_o, rd_y, rd_c;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vid_xport dut (
        .clk(clk), .rst_n(rst_n), .cfg_req_in(cfg_req_in), .cfg_wide(cfg_wide),
        .cfg_embedded(cfg_embedded), .cfg_h_fall(cfg_h_fall), .cfg_v_fall(cfg_v_fall),
        .cfg_fid_inv(cfg_fid_inv), .xp_tri(xp_tri), .dec_data(dec_data),
        .dec_valid(dec_valid), .dec_href(dec_href), .dec_vref(dec_vref),
        .xp_data_i(xp_data_i), .xp_aux_i(xp_aux_i), .xp_valid_i(xp_valid_i),
        .xp_h_i(xp_h_i), .xp_v_i(xp_v_i), .xp_clk_o(xp_clk_o), .xp_data_o(xp_data_o),
        .xp_valid_o(xp_valid_o), .xp_h_o(xp_h_o), .xp_v_o(xp_v_o), .xp_oe(xp_oe),
        .xp_rdy(xp_rdy), .in_field_id(in_field_id), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_y(rd_y), .rd_c(rd_c)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic [7:0] a);
        xp_data_i = d; xp_aux_i = a; xp_valid_i = 1'b1;
        @(negedge clk);
        xp_valid_i = 1'b0; xp_data_i = 8'h99;
    endtask

    task automatic pop_chk(input string req, input logic [7:0] c, input logic [7:0] y);
        chk(req, {31'd0, rd_valid}, 32'd1);
        chk(req, {16'd0, rd_c, rd_y}, {16'd0, c, y});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 oe", {31'd0, xp_oe}, 32'd1);
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        chk("R1 rdy", {31'd0, xp_rdy}, 32'd1);
    endtask

    task automatic t_output_copy();
        dec_data = 8'h5A; dec_valid = 1; dec_href = 1; dec_vref = 0;
        #1;
        chk("R2 copy", {23'd0, xp_clk_o, xp_data_o, xp_valid_o, xp_h_o, xp_v_o, xp_oe},
            {23'd0, clk, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b1});
        dec_data = 8'hC3; dec_valid = 0; dec_href = 0;
        #1;
        chk("R2 copy2", {24'd0, xp_data_o}, 32'h0000_00C3);
        xp_tri = 1; #1;
        chk("R3 tri out", {31'd0, xp_oe}, 32'd0);
        xp_tri = 0;
        @(negedge clk);
    endtask

    task automatic t_switch_in();
        cfg_req_in = 1; tick(3);
        chk("R4 no boundary", {31'd0, xp_oe}, 32'd1);
        cfg_req_in = 0; tick(1);
        dec_vref = 1; tick(1); dec_vref = 0; tick(2);
        chk("R4 withdrawn", {31'd0, xp_oe}, 32'd1);
        cfg_req_in = 1; tick(2);
        dec_vref = 1; tick(1);
        chk("R4 switched", {31'd0, xp_oe}, 32'd0);
        dec_vref = 0; tick(1);
        xp_tri = 1; #1;
        chk("R3 tri in", {31'd0, xp_oe}, 32'd0);
        xp_tri = 0;
        tick(1);
    endtask

    task automatic t_narrow();
        send(8'h10, 8'h00); tick(1);
        send(8'h20, 8'h00);
        send(8'h30, 8'h00); tick(2);
        send(8'h40, 8'h00);
        pop_chk("R6 pair0", 8'h10, 8'h20);
        pop_chk("R6 pair1", 8'h30, 8'h40);
        chk("R6 empty", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic t_h_restart();
        send(8'h11, 8'h00);
        xp_h_i = 1; tick(1);
        send(8'h21, 8'h00); send(8'h22, 8'h00);
        pop_chk("R8 rising", 8'h21, 8'h22);
        cfg_h_fall = 1; tick(1);
        send(8'h31, 8'h00);
        xp_h_i = 0; tick(1);
        send(8'h41, 8'h00); send(8'h42, 8'h00);
        pop_chk("R8 falling", 8'h41, 8'h42);
        chk("R8 empty", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic t_v_field();
        cfg_h_fall = 0;
        xp_h_i = 1; tick(1);
        xp_v_i = 1; tick(1);
        chk("R9 rising fid", {31'd0, in_field_id}, 32'd1);
        cfg_v_fall = 1; cfg_fid_inv = 1; tick(1);
        xp_v_i = 0; tick(1);
        chk("R9 falling inv", {31'd0, in_field_id}, 32'd0);
        xp_h_i = 0; tick(1);
        xp_v_i = 1; tick(1);
        chk("R9 inactive edge", {31'd0, in_field_id}, 32'd0);
        cfg_fid_inv = 0; tick(1);
    endtask

    task automatic t_wide();
        cfg_wide = 1; tick(1);
        send(8'hA1, 8'hB1); tick(1);
        send(8'hA2, 8'hB2);
        pop_chk("R7 wide0", 8'hB1, 8'hA1);
        pop_chk("R7 wide1", 8'hB2, 8'hA2);
    endtask

    task automatic t_fill();
        for (int i = 1; i <= 4; i++) send(8'(i), 8'(8'h80 + i));
        chk("R11 four free", {31'd0, xp_rdy}, 32'd1);
        send(8'h05, 8'h85);
        chk("R11 three free", {31'd0, xp_rdy}, 32'd0);
        for (int i = 6; i <= 9; i++) send(8'(i), 8'(8'h80 + i));
        for (int i = 1; i <= 8; i++) pop_chk("R12 order", 8'(8'h80 + i), 8'(i));
        chk("R11 drop when full", {31'd0, rd_valid}, 32'd0);
        chk("R11 rdy empty", {31'd0, xp_rdy}, 32'd1);
        cfg_wide = 0; tick(1);
    endtask

    task automatic t_embedded();
        cfg_embedded = 1; cfg_v_fall = 0; tick(1);
        send(8'h55, 8'h00);
        send(8'hFF, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00); send(8'h80, 8'h00);
        chk("R10 sav fid", {31'd0, in_field_id}, 32'd0);
        send(8'h01, 8'h00); send(8'h02, 8'h00); send(8'h03, 8'h00); send(8'h04, 8'h00);
        send(8'hFF, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00); send(8'hD0, 8'h00);
        send(8'h77, 8'h00); send(8'h78, 8'h00);
        chk("R10 eav fid", {31'd0, in_field_id}, 32'd1);
        pop_chk("R10 pair0", 8'h01, 8'h02);
        pop_chk("R10 pair1", 8'h03, 8'h04);
        chk("R10 codes not stored", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic t_switch_out();
        cfg_req_in = 0; tick(1);
        send(8'h12, 8'h00); send(8'h34, 8'h00); tick(2);
        chk("R5 waits", {31'd0, xp_oe}, 32'd0);
        send(8'hFF, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00);
        send(8'hD0, 8'h00);
        chk("R5 same field", {31'd0, xp_oe}, 32'd0);
        send(8'hFF, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00);
        send(8'h80, 8'h00);
        chk("R5 switched out", {31'd0, xp_oe}, 32'd1);
        while (rd_valid) begin rd_en = 1; tick(1); rd_en = 0; end
        cfg_embedded = 0; tick(1);
        send(8'h61, 8'h00); send(8'h62, 8'h00); send(8'h63, 8'h00); send(8'h64, 8'h00);
        chk("R6 ignored in output", {31'd0, rd_valid}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_output_copy();
        t_switch_in();
        t_narrow();
        t_h_restart();
        t_v_field();
        t_wide();
        t_fill();
        t_embedded();
        t_switch_out();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule